// File: doc/BRIEF.md
# Programmable Address Translation Window Table

This block translates 64-bit request addresses for a bus bridge. It keeps two separate tables of translation windows. The inbound table carries traffic from the link side toward the system bus, and the outbound table carries traffic from the system bus toward the link side. Software fills both tables through a plain 32-bit register write/read port.

Each entry holds the following fields:
- an enable bit
- a power-of-two window size code
- a 4 KiB-aligned source base
- a 4 KiB-aligned translated base
- a 24-bit parameter word that tags the target space

Each direction has its own request port. A request address is compared against every enabled entry of that direction's table. On a hit, the block replaces the address bits above the window size with the translated base and keeps the offset below the window size. It returns the translated address and the entry's parameter word. On a miss, it flags the miss and returns the address unchanged.

Results are registered, so they appear one clock after the request. A register write changes lookups from the next cycle onward.

Top module: `xlat_window_table`

## Requirements
- R1: Register map. `reg_addr[10]` picks the table (0 = inbound, 1 = outbound). `reg_addr[9:5]` is the entry index, and `reg_addr[4:2]` picks the word. The words are:
  - word 0 (offset 0x0): source-low, with enable in bit 0, size code in bits 6:1 and source bits 31:12 in bits 31:12. Bits 11:7 read as zero.
  - word 1 (offset 0x4): source bits 63:32.
  - word 2 (offset 0x8): translated bits 31:12 in bits 31:12. Bits 11:0 are not stored and read as zero.
  - word 3 (offset 0xC): translated bits 63:32.
  - word 4 (offset 0x10): the parameter, in bits 23:0. Bits 31:24 read as zero.
- R2: While `rst_n` is low at a clock edge, every entry is cleared and disabled, so all words read zero. Both response valids are low on the next cycle.
- R3: A request hits an entry when the entry is enabled and the address bits at and above the window exponent e equal the source bits at and above e. The exponent is e = code+1, and codes below 11 act as e = 12. Windows from 4 KiB to 8 GiB and larger are supported.
- R4: The translated address on a hit has two parts. Bits at and above e come from the translated base, and bits below e come from the request. A translated base of zero is allowed, and bits 11:0 always pass through.
- R5: On a hit, the response parameter is the winning entry's 24-bit parameter. On a miss, it is zero.
- R6: When several entries hit, the entry with the lowest index supplies the result.
- R7: When no entry hits, the miss flag is high and the response address equals the request address.
- R8: A response is valid exactly one clock after a valid request on the same direction's port, and is low otherwise.
- R9: A request issued in the same cycle as a register write sees the old table contents. A request issued on the next cycle sees the new contents.
- R10: A write to one table never changes the lookup results of the other table.
- R11: A disabled entry never hits, whatever its other fields hold.
- R12: The following accesses are ignored on write and read as zero:
  - an index at or above the table's entry count
  - a word offset of 0x14 to 0x1C
  - any address with `reg_addr[11]` set

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| in_req_valid | input | 1 | Inbound request valid |
| in_req_addr | input | 64 | Inbound request address |
| in_rsp_valid | output | 1 | Inbound response valid |
| in_rsp_miss | output | 1 | Inbound miss flag |
| in_rsp_addr | output | 64 | Inbound translated address |
| in_rsp_param | output | 24 | Inbound parameter word |
| out_req_valid | input | 1 | Outbound request valid |
| out_req_addr | input | 64 | Outbound request address |
| out_rsp_valid | output | 1 | Outbound response valid |
| out_rsp_miss | output | 1 | Outbound miss flag |
| out_rsp_addr | output | 64 | Outbound translated address |
| out_rsp_param | output | 24 | Outbound parameter word |

## Verification
A register write and a lookup in the same table can arrive on the same clock edge. The bench provokes this by enabling an entry that overlaps a lower-priority window while it issues a request to the shared range in the same cycle. The expected result comes from the behavioural model before that write is applied. The next request must then reflect the new entry, which judges the old-before-new rule of R9. The same pattern, with the write aimed at the other table, judges R10. Every clock, both response ports are compared with the model.

// File: rtl/xlat_pkg.sv
// Shared definitions for the address translation window table.
// Assumes 64-bit request addresses and 4 KiB minimum window granularity.
package xlat_pkg;
    localparam int ADDR_W     = 64;
    localparam int PARAM_W    = 24;
    localparam int PAGE_LSB   = 12;
    localparam int CODE_W     = 6;
    localparam int REG_AW     = 12;
    localparam int REGION_BIT = 11;
    localparam int TBL_BIT    = 10;
    localparam int IDX_LSB    = 5;
    localparam int IDX_W      = TBL_BIT - IDX_LSB;
    localparam int WORD_LSB   = 2;
    localparam int WORD_W     = IDX_LSB - WORD_LSB;

    localparam logic [WORD_W-1:0] W_SRC_LO  = 3'd0;
    localparam logic [WORD_W-1:0] W_SRC_HI  = 3'd1;
    localparam logic [WORD_W-1:0] W_TRSL_LO = 3'd2;
    localparam logic [WORD_W-1:0] W_TRSL_HI = 3'd3;
    localparam logic [WORD_W-1:0] W_PARAM   = 3'd4;

    typedef struct packed {
        logic                       en;
        logic [CODE_W-1:0]          code;
        logic [ADDR_W-1:PAGE_LSB]   src;
        logic [ADDR_W-1:PAGE_LSB]   trsl;
        logic [PARAM_W-1:0]         param;
    } xlat_entry_t;

    // Mask of the address bits that select the window (at and above the exponent).
    function automatic logic [ADDR_W-1:0] win_mask(input logic [CODE_W-1:0] code);
        logic [6:0] e;
        e = {1'b0, code} + 7'd1;
        if (e < 7'(PAGE_LSB)) e = 7'(PAGE_LSB);
        if (e >= 7'(ADDR_W)) return '0;
        return {ADDR_W{1'b1}} << e;
    endfunction
endpackage

// File: rtl/xlat_entry_regs.sv
// Register storage for one translation table of N entries.
// Assumes the caller has already decoded the table select; writes to an
// index at or above N are dropped and such reads return zero.
module xlat_entry_regs
    import xlat_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [WORD_W-1:0]    word,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output xlat_entry_t          entries [N]
);
    logic [7:0]  unused_wdata;
    xlat_entry_t rd_ent;
    logic        rd_ok;

    assign unused_wdata = wdata[31:24] ^ {wdata[11:7], 3'b0} ^ {1'b0, wdata[6:0] & 7'h0};

    // Update the addressed entry word; reset disables and clears all entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) entries[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (idx == IDX_W'(i)) begin
                    case (word)
                        W_SRC_LO: begin
                            entries[i].en          <= wdata[0];
                            entries[i].code        <= wdata[CODE_W:1];
                            entries[i].src[31:12]  <= wdata[31:12];
                        end
                        W_SRC_HI:  entries[i].src[63:32]  <= wdata;
                        W_TRSL_LO: entries[i].trsl[31:12] <= wdata[31:12];
                        W_TRSL_HI: entries[i].trsl[63:32] <= wdata;
                        W_PARAM:   entries[i].param       <= wdata[PARAM_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Select the entry named by the read index (none when out of range).
    always_comb begin
        rd_ent = '0;
        rd_ok  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_ent = entries[i];
                rd_ok  = 1'b1;
            end
        end
    end

    // Pack the selected word with reserved fields as zero.
    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            case (word)
                W_SRC_LO:  rdata = {rd_ent.src[31:12], 5'b0, rd_ent.code, rd_ent.en};
                W_SRC_HI:  rdata = rd_ent.src[63:32];
                W_TRSL_LO: rdata = {rd_ent.trsl[31:12], 12'b0};
                W_TRSL_HI: rdata = rd_ent.trsl[63:32];
                W_PARAM:   rdata = {8'b0, rd_ent.param};
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/xlat_lookup.sv
// Parallel window match, lowest-index priority and offset substitution
// for one table. Result is registered: valid one clock after the request.
// Assumes entries are stable for the cycle in which a request is sampled.
module xlat_lookup
    import xlat_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  xlat_entry_t         entries [N],
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_valid,
    output logic                rsp_miss,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic [PARAM_W-1:0]  rsp_param
);
    logic [N-1:0]        hit;
    logic [ADDR_W-1:0]   mask [N];
    logic [ADDR_W-1:0]   sel_addr;
    logic [PARAM_W-1:0]  sel_param;
    logic                sel_miss;

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign mask[g] = win_mask(entries[g].code);
        assign hit[g]  = entries[g].en &&
                         (((req_addr ^ {entries[g].src, 12'b0}) & mask[g]) == '0);
    end

    // Pick the lowest-index hit and splice base and offset.
    always_comb begin
        sel_addr  = req_addr;
        sel_param = '0;
        sel_miss  = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_miss  = 1'b0;
                sel_addr  = ({entries[i].trsl, 12'b0} & mask[i]) | (req_addr & ~mask[i]);
                sel_param = entries[i].param;
            end
        end
    end

    // Register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_addr  <= '0;
            rsp_param <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_miss  <= sel_miss;
                rsp_addr  <= sel_addr;
                rsp_param <= sel_param;
            end
        end
    end
endmodule

// File: rtl/xlat_window_table.sv
// Top of the two-direction address translation window table.
// Decodes the register port into the inbound and outbound tables and
// runs one lookup pipeline per direction. Assumes IN_ENTRIES and
// OUT_ENTRIES are each between 1 and 32.
module xlat_window_table
    import xlat_pkg::*;
#(
    parameter int IN_ENTRIES  = 4,
    parameter int OUT_ENTRIES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 in_req_valid,
    input  logic [ADDR_W-1:0]    in_req_addr,
    output logic                 in_rsp_valid,
    output logic                 in_rsp_miss,
    output logic [ADDR_W-1:0]    in_rsp_addr,
    output logic [PARAM_W-1:0]   in_rsp_param,
    input  logic                 out_req_valid,
    input  logic [ADDR_W-1:0]    out_req_addr,
    output logic                 out_rsp_valid,
    output logic                 out_rsp_miss,
    output logic [ADDR_W-1:0]    out_rsp_addr,
    output logic [PARAM_W-1:0]   out_rsp_param
);
    logic               in_region;
    logic               pick_out;
    logic [IDX_W-1:0]   idx;
    logic [WORD_W-1:0]  word;
    logic [1:0]         unused_lsb;
    logic [31:0]        in_rdata, out_rdata;
    xlat_entry_t        in_tbl  [IN_ENTRIES];
    xlat_entry_t        out_tbl [OUT_ENTRIES];

    assign in_region  = ~reg_addr[REGION_BIT];
    assign pick_out   = reg_addr[TBL_BIT];
    assign idx        = reg_addr[TBL_BIT-1:IDX_LSB];
    assign word       = reg_addr[IDX_LSB-1:WORD_LSB];
    assign unused_lsb = reg_addr[WORD_LSB-1:0];

    xlat_entry_regs #(.N(IN_ENTRIES)) u_in_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr & in_region & ~pick_out),
        .idx(idx), .word(word), .wdata(reg_wdata),
        .rdata(in_rdata), .entries(in_tbl)
    );

    xlat_entry_regs #(.N(OUT_ENTRIES)) u_out_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr & in_region & pick_out),
        .idx(idx), .word(word), .wdata(reg_wdata),
        .rdata(out_rdata), .entries(out_tbl)
    );

    // Return the addressed table's word, zero outside the table region.
    always_comb begin
        if (!in_region)    reg_rdata = '0;
        else if (pick_out) reg_rdata = out_rdata;
        else               reg_rdata = in_rdata;
    end

    xlat_lookup #(.N(IN_ENTRIES)) u_in_lookup (
        .clk(clk), .rst_n(rst_n), .entries(in_tbl),
        .req_valid(in_req_valid), .req_addr(in_req_addr),
        .rsp_valid(in_rsp_valid), .rsp_miss(in_rsp_miss),
        .rsp_addr(in_rsp_addr), .rsp_param(in_rsp_param)
    );

    xlat_lookup #(.N(OUT_ENTRIES)) u_out_lookup (
        .clk(clk), .rst_n(rst_n), .entries(out_tbl),
        .req_valid(out_req_valid), .req_addr(out_req_addr),
        .rsp_valid(out_rsp_valid), .rsp_miss(out_rsp_miss),
        .rsp_addr(out_rsp_addr), .rsp_param(out_rsp_param)
    );
endmodule

// File: rtl/xlat_window_table_chk.sv
// Port-level checks for the translation table; bound into the top.
module xlat_window_table_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_req_valid,
    input logic [63:0] in_req_addr,
    input logic        in_rsp_valid,
    input logic        in_rsp_miss,
    input logic [63:0] in_rsp_addr,
    input logic [23:0] in_rsp_param,
    input logic        out_req_valid,
    input logic [63:0] out_req_addr,
    input logic        out_rsp_valid,
    input logic        out_rsp_miss,
    input logic [63:0] out_rsp_addr,
    input logic [23:0] out_rsp_param
);
    assert_in_reset_idle_R2: assert property (@(posedge clk) !rst_n |=> !in_rsp_valid);
    assert_out_reset_idle_R2: assert property (@(posedge clk) !rst_n |=> !out_rsp_valid);

    assert_in_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_req_valid |=> in_rsp_valid);
    assert_in_rsp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_req_valid |=> !in_rsp_valid);
    assert_out_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_valid |=> out_rsp_valid);
    assert_out_rsp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_req_valid |=> !out_rsp_valid);

    assert_in_miss_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_req_valid |=> (!in_rsp_miss || in_rsp_addr == $past(in_req_addr)));
    assert_out_miss_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_valid |=> (!out_rsp_miss || out_rsp_addr == $past(out_req_addr)));

    assert_in_miss_param_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rsp_valid && in_rsp_miss) |-> in_rsp_param == 24'h0);
    assert_out_miss_param_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rsp_valid && out_rsp_miss) |-> out_rsp_param == 24'h0);

    assert_in_page_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_req_valid |=> in_rsp_addr[11:0] == $past(in_req_addr[11:0]));
    assert_out_page_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_req_valid |=> out_rsp_addr[11:0] == $past(out_req_addr[11:0]));
endmodule

bind xlat_window_table xlat_window_table_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_req_valid(in_req_valid), .in_req_addr(in_req_addr),
    .in_rsp_valid(in_rsp_valid), .in_rsp_miss(in_rsp_miss),
    .in_rsp_addr(in_rsp_addr), .in_rsp_param(in_rsp_param),
    .out_req_valid(out_req_valid), .out_req_addr(out_req_addr),
    .out_rsp_valid(out_rsp_valid), .out_rsp_miss(out_rsp_miss),
    .out_rsp_addr(out_rsp_addr), .out_rsp_param(out_rsp_param)
);

// File: tb/xlat_window_table_tb.sv
// Self-checking bench with a behavioural reference model compared every clock.
module xlat_window_table_tb;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        in_req_valid, out_req_valid;
    logic [63:0] in_req_addr, out_req_addr;
    logic        in_rsp_valid, in_rsp_miss, out_rsp_valid, out_rsp_miss;
    logic [63:0] in_rsp_addr, out_rsp_addr;
    logic [23:0] in_rsp_param, out_rsp_param;

    int errors = 0;
    int checks = 0;

    // Reference model state: [table][entry], table 0 inbound, 1 outbound.
    bit          m_en   [2][NE];
    int          m_code [2][NE];
    logic [63:0] m_src  [2][NE];
    logic [63:0] m_trsl [2][NE];
    logic [23:0] m_prm  [2][NE];

    always #5 clk = ~clk;

    xlat_window_table u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_req_valid(in_req_valid), .in_req_addr(in_req_addr),
        .in_rsp_valid(in_rsp_valid), .in_rsp_miss(in_rsp_miss),
        .in_rsp_addr(in_rsp_addr), .in_rsp_param(in_rsp_param),
        .out_req_valid(out_req_valid), .out_req_addr(out_req_addr),
        .out_rsp_valid(out_rsp_valid), .out_rsp_miss(out_rsp_miss),
        .out_rsp_addr(out_rsp_addr), .out_rsp_param(out_rsp_param)
    );

    task automatic model_reset();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < NE; i++) begin
                m_en[t][i] = 0; m_code[t][i] = 0; m_src[t][i] = '0;
                m_trsl[t][i] = '0; m_prm[t][i] = '0;
            end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int t, i, w;
        if (a[11]) return;
        t = int'(a[10]); i = int'(a[9:5]); w = int'(a[4:2]);
        if (i >= NE) return;
        case (w)
            0: begin
                m_en[t][i] = d[0]; m_code[t][i] = int'(d[6:1]);
                m_src[t][i][31:0] = {d[31:12], 12'h000};
            end
            1: m_src[t][i][63:32] = d;
            2: m_trsl[t][i][31:0] = {d[31:12], 12'h000};
            3: m_trsl[t][i][63:32] = d;
            4: m_prm[t][i] = d[23:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int t, i, w;
        if (a[11]) return 32'h0;
        t = int'(a[10]); i = int'(a[9:5]); w = int'(a[4:2]);
        if (i >= NE) return 32'h0;
        case (w)
            0: return {m_src[t][i][31:12], 5'b0, 6'(m_code[t][i]), m_en[t][i]};
            1: return m_src[t][i][63:32];
            2: return {m_trsl[t][i][31:12], 12'h000};
            3: return m_trsl[t][i][63:32];
            4: return {8'h00, m_prm[t][i]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_lookup(input int t, input logic [63:0] a,
                                output bit miss, output logic [63:0] oa, output logic [23:0] op);
        miss = 1; oa = a; op = '0;
        for (int i = 0; i < NE; i++) begin
            int e;
            e = m_code[t][i] + 1;
            if (e < 12) e = 12;
            if (miss && m_en[t][i] && ((a >> e) == (m_src[t][i] >> e))) begin
                miss = 0;
                oa = ((m_trsl[t][i] >> e) << e) | (a & ((64'd1 << e) - 64'd1));
                op = m_prm[t][i];
            end
        end
    endtask

    task automatic cmp_port(input string tag, input string dir, input bit ev, input bit em,
                            input logic [63:0] ea, input logic [23:0] ep,
                            input logic av, input logic am, input logic [63:0] aa,
                            input logic [23:0] ap);
        checks++;
        if (av !== ev || (ev && (am !== em || aa !== ea || ap !== ep))) begin
            errors++;
            $display("FAIL %s %s: got v=%0d m=%0d a=%h p=%h exp v=%0d m=%0d a=%h p=%h",
                     tag, dir, av, am, aa, ap, ev, em, ea, ep);
        end
    endtask

    // One clock: optional write plus optional requests, compared a cycle later.
    task automatic step(input string tag, input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit iv, input logic [63:0] ia, input bit ov, input logic [63:0] oa);
        bit em_i, em_o;
        logic [63:0] ea_i, ea_o;
        logic [23:0] ep_i, ep_o;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        in_req_valid = iv; in_req_addr = ia;
        out_req_valid = ov; out_req_addr = oa;
        model_lookup(0, ia, em_i, ea_i, ep_i);
        model_lookup(1, oa, em_o, ea_o, ep_o);
        @(posedge clk);
        if (wr) model_write(a, d);
        @(negedge clk);
        reg_wr = 0; in_req_valid = 0; out_req_valid = 0;
        cmp_port(tag, "in", iv, em_i, ea_i, ep_i, in_rsp_valid, in_rsp_miss, in_rsp_addr, in_rsp_param);
        cmp_port(tag, "out", ov, em_o, ea_o, ep_o, out_rsp_valid, out_rsp_miss, out_rsp_addr, out_rsp_param);
    endtask

    task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
        step(tag, 1, a, d, 0, 64'h0, 0, 64'h0);
    endtask

    task automatic look(input string tag, input bit iv, input logic [63:0] ia,
                        input bit ov, input logic [63:0] oa);
        step(tag, 0, 12'h0, 32'h0, iv, ia, ov, oa);
    endtask

    task automatic prog(input int t, input int i, input logic [63:0] src, input logic [63:0] trsl,
                        input int code, input logic [23:0] prm, input bit en);
        logic [11:0] b;
        b = 12'((t << 10) | (i << 5));
        wr("R1", b | 12'h04, src[63:32]);
        wr("R1", b | 12'h08, trsl[31:0]);
        wr("R1", b | 12'h0C, trsl[63:32]);
        wr("R1", b | 12'h10, {8'h00, prm});
        wr("R1", b, {src[31:12], 5'b0, 6'(code), en});
    endtask

    task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp || model_read(a) !== exp) begin
            errors++;
            $display("FAIL %s read %h: got %h exp %h (model %h)", tag, a, reg_rdata, exp, model_read(a));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] r;
        rst_n = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        in_req_valid = 0; in_req_addr = '0; out_req_valid = 0; out_req_addr = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state
        cmp_port("R2", "in", 0, 0, 0, 0, in_rsp_valid, in_rsp_miss, in_rsp_addr, in_rsp_param);
        cmp_port("R2", "out", 0, 0, 0, 0, out_rsp_valid, out_rsp_miss, out_rsp_addr, out_rsp_param);
        rst_n = 1;
        rd_check("R2", 12'h000, 32'h0);
        rd_check("R2", 12'h470, 32'h0);
        // R7/R11: empty tables miss and pass through
        look("R7", 1, 64'h0000_0012_3456_789A, 1, 64'hFFFF_0000_1234_5000);
        look("R8", 0, 64'h0, 0, 64'h0);

        // Outbound: config (trsl 0), IO, 32-bit memory, 64-bit memory
        prog(1, 0, 64'h4000_0000, 64'h0, 27, 24'h000001, 1);
        prog(1, 1, 64'h5F80_0000, 64'h5F80_0000, 22, 24'h020000, 1);
        prog(1, 2, 64'h5000_0000, 64'h5000_0000, 26, 24'h000000, 1);
        prog(1, 3, 64'h40_0000_0000, 64'h40_0000_0000, 32, 24'h000000, 1);
        // Inbound: 4 KiB device window, 2 GiB and 8 GiB memory windows
        prog(0, 0, 64'h2C1C_0000, 64'h2C1C_0000, 11, 24'h420004, 1);
        prog(0, 1, 64'h8000_0000, 64'h1_0000_0000, 30, 24'h4E0004, 1);
        prog(0, 2, 64'h8_8000_0000, 64'h8_8000_0000, 32, 24'h4E0004, 1);

        // R1: readback of fields
        rd_check("R1", 12'h400, 32'h4000_0037);
        rd_check("R1", 12'h408, 32'h0);
        rd_check("R1", 12'h410, 32'h0000_0001);
        rd_check("R1", 12'h46C, 32'h0000_0040);
        // R1: reserved and ignored bits read zero
        wr("R1", 12'h060, 32'hFFFF_FFFF);
        rd_check("R1", 12'h060, 32'hFFFF_F07F);
        wr("R1", 12'h068, 32'hABCD_EFFF);
        rd_check("R1", 12'h068, 32'hABCD_E000);
        wr("R1", 12'h070, 32'hFFFF_FFFF);
        rd_check("R1", 12'h070, 32'h00FF_FFFF);
        wr("R11", 12'h060, 32'h0);

        // R3/R4/R5: hits in each outbound window
        look("R4", 0, 64'h0, 1, 64'h4012_3456);
        look("R4", 0, 64'h0, 1, 64'h5F8A_BCDE);
        look("R5", 0, 64'h0, 1, 64'h57FF_FFF0);
        look("R3", 0, 64'h0, 1, 64'h41_FFFF_FFFF);
        look("R3", 0, 64'h0, 1, 64'h42_0000_0000);
        look("R7", 0, 64'h0, 1, 64'h1234_5678);
        // Inbound hits with base substitution
        look("R4", 1, 64'h8765_4321, 1, 64'h5000_0004);
        look("R3", 1, 64'h9_FFFF_FFFF, 0, 64'h0);
        look("R3", 1, 64'h2C1C_0FFF, 0, 64'h0);
        look("R3", 1, 64'h2C1C_1000, 0, 64'h0);

        // R6: overlapping window at index 3
        prog(0, 3, 64'h2C1C_0000, 64'h9000_0000, 20, 24'h000000, 1);
        look("R6", 1, 64'h2C1C_0010, 0, 64'h0);
        look("R6", 1, 64'h2C1C_1010, 0, 64'h0);
        // R11: disable index 0, index 3 takes over
        wr("R11", 12'h000, 32'h2C1C_0016);
        look("R11", 1, 64'h2C1C_0010, 0, 64'h0);
        // R9: re-enable in same cycle as a lookup, then next cycle
        step("R9", 1, 12'h000, 32'h2C1C_0017, 1, 64'h2C1C_0010, 0, 64'h0);
        look("R9", 1, 64'h2C1C_0010, 0, 64'h0);
        // R10: disable outbound config window while inbound looks up
        step("R10", 1, 12'h400, 32'h4000_0036, 1, 64'h2C1C_0010, 1, 64'h4000_0100);
        look("R10", 1, 64'h2C1C_0010, 1, 64'h4000_0100);

        // R3: small code clamps to 4 KiB
        prog(0, 3, 64'h7000_0000, 64'hA000_0000, 3, 24'h000123, 1);
        look("R3", 1, 64'h7000_0FFF, 0, 64'h0);
        look("R3", 1, 64'h7000_1000, 0, 64'h0);

        // R12: out-of-range index, word gap, and region bit 11
        wr("R12", 12'h0A0, 32'hFFFF_F07F);
        rd_check("R12", 12'h0A0, 32'h0);
        wr("R12", 12'h014, 32'hFFFF_FFFF);
        rd_check("R12", 12'h014, 32'h0);
        wr("R12", 12'h800, 32'h0000_007F);
        rd_check("R12", 12'h800, 32'h0);
        rd_check("R12", 12'h000, 32'h2C1C_0017);
        look("R12", 1, 64'h3333_3000, 1, 64'h6666_6000);

        // Sweep of mixed lookups on both ports
        r = 64'h9E37_79B9_7F4A_7C15;
        for (int n = 0; n < 300; n++) begin
            logic [63:0] base_i, base_o;
            r ^= r << 13; r ^= r >> 7; r ^= r << 17;
            case (r[2:0])
                3'd0: begin base_i = 64'h2C1C_0000;   base_o = 64'h4000_0000;   end
                3'd1: begin base_i = 64'h8000_0000;   base_o = 64'h5F80_0000;   end
                3'd2: begin base_i = 64'h8_8000_0000; base_o = 64'h5000_0000;   end
                3'd3: begin base_i = 64'h7000_0000;   base_o = 64'h40_0000_0000; end
                3'd4: begin base_i = 64'h7FFF_F000;   base_o = 64'h41_FFFF_F000; end
                3'd5: begin base_i = 64'hA_0000_0000; base_o = 64'h57FF_0000;   end
                default: begin base_i = r;            base_o = ~r;              end
            endcase
            look("R3", r[3], base_i + {40'h0, r[63:40]}, r[4], base_o + {44'h0, r[59:40]});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule